// File: doc/BRIEF.md
# Processor Reset and Stop Sequencer

This block is the control sequencer of a small 8-bit processor core. After reset it performs three throw-away stack reads, which walk the stack pointer from 0x00 down to 0xFD, and then it fetches the two-byte start address from the reset vector over a simple synchronous read bus. It loads the program counter from those two bytes and then opens instruction fetch.

The block does not decode instructions. An external decoder presents an opcode together with its length in bytes and a valid strobe. This block accepts that opcode only while the core is running. It advances the program counter and pulses `executed` once per completed instruction.

Two opcodes idle the core. The stop opcode parks it until the next reset. The wait opcode parks it until an interrupt line is raised. NMI always wakes the core. IRQ also wakes it when the interrupt-disable flag is set, but in that case no interrupt is taken and execution continues at the next instruction.

Top module: `core_ctl_seq`

## Requirements
- R1: On each of the first three cycles after reset is released, the block issues a bus read (`bus_rd`=1). The read addresses are 0x0100, 0x01FF and 0x01FE, in that order. The returned data is discarded.
- R2: While `rst_n` is low, `sp` is 0x00. It is 0xFF, 0xFE and 0xFD after the first, second and third dummy read. It is 0xFD when fetch opens.
- R3: On the fourth and fifth cycles after release, the block reads 0xFFFC and then 0xFFFD. Read data arrives one cycle after its strobe. On the seventh cycle `fetch_en` is 1 and `pc` = {data@0xFFFD, data@0xFFFC}.
- R4: `fetch_en` is 1 only in the running state. No bus read is issued while running, halted or waiting, and `bus_rd` is 0 while `rst_n` is low.
- R5: In the running state, `op_valid`=1 with any opcode other than 0xDB or 0xCB advances `pc` by `op_len` and pulses `executed` for exactly one cycle. Both effects appear on the cycle after the strobe.
- R6: Opcode 0xDB (stop) pulses `executed`, advances `pc` by 1, sets `halted` and clears `fetch_en`.
- R7: While halted, `op_valid`, `irq` and `nmi` have no effect: `executed` stays 0, `pc` is unchanged and `halted` stays 1.
- R8: Only reset leaves the halted state. Reset clears `halted` and replays the full R1–R3 sequence, so the core starts from the vector again.
- R9: Opcode 0xCB (wait) pulses `executed`, advances `pc` by 1, sets `waiting` and clears `fetch_en`. `op_valid` is ignored while waiting.
- R10: While waiting, `nmi`=1 wakes the core. On the next cycle `waiting` is 0, `fetch_en` is 1 and `take_int` pulses for one cycle.
- R11: While waiting, `irq`=1 also wakes the core. `take_int` pulses only if `irq_mask` is 0. With `irq_mask` = 1 the core resumes with `take_int` held at 0 and `pc` unchanged.
- R12: `op_valid` during the reset sequence is ignored: no `executed` pulse occurs, and `pc` still loads the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | output | 16 | Read address |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid one cycle after the strobe |
| op_valid | input | 1 | Decoded opcode present |
| opcode | input | 8 | Opcode value |
| op_len | input | 2 | Instruction length in bytes |
| irq | input | 1 | Maskable interrupt request (level) |
| nmi | input | 1 | Non-maskable interrupt request (level) |
| irq_mask | input | 1 | Interrupt-disable flag |
| fetch_en | output | 1 | Instruction fetch permitted |
| executed | output | 1 | One-cycle pulse per completed instruction |
| halted | output | 1 | Core is stopped until reset |
| waiting | output | 1 | Core is waiting for an interrupt |
| take_int | output | 1 | Pulse: the wake-up interrupt should be serviced |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |

## Verification
The assertions check several rules on every cycle:
- 0x01FF is only ever read right after 0x0100.
- The stack pointer is 0xFD when the vector fetch begins.
- Every `executed` pulse follows an opcode strobe.
- The halted state is never left and `pc` never moves while halted.
- `take_int` only follows NMI, or IRQ with the mask clear.

Only the bench scenarios can show the rest:
- The exact read addresses and the vector value landing in `pc`.
- That a second reset clears the stopped core.
- That strobes during the reset sequence, during halt and during wait are ignored.
- The difference between a masked and an unmasked IRQ wake-up.

// File: rtl/core_seq_pkg.sv
// Package: shared state encoding for the reset/stop sequencer.
// Assumes one state register owned by seq_fsm and read by the other units.
package core_seq_pkg;
    typedef enum logic [3:0] {
        S_DUMMY0,
        S_DUMMY1,
        S_DUMMY2,
        S_VLO,
        S_VHI,
        S_LOAD,
        S_RUN,
        S_HALT,
        S_WAIT
    } seq_state_e;
endpackage

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Walks the reset sequence, then holds the running, stopped and waiting states.
// Assumes rst_n is synchronous and active low, and that irq/nmi are level signals.
module seq_fsm
    import core_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] OP_STOP = 8'hDB,
    parameter logic [DW-1:0] OP_WAIT = 8'hCB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [DW-1:0]   opcode,
    input  logic            irq,
    input  logic            nmi,
    input  logic            irq_mask,
    output seq_state_e      state_q,
    output logic            accept,
    output logic            single_byte,
    output logic            take_int_q
);
    seq_state_e state_d;
    logic       wake;

    // Opcode acceptance and wake-up conditions.
    always_comb begin
        accept      = (state_q == S_RUN) && op_valid;
        single_byte = (opcode == OP_STOP) || (opcode == OP_WAIT);
        wake        = (state_q == S_WAIT) && (nmi || irq);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_DUMMY0: state_d = S_DUMMY1;
            S_DUMMY1: state_d = S_DUMMY2;
            S_DUMMY2: state_d = S_VLO;
            S_VLO:    state_d = S_VHI;
            S_VHI:    state_d = S_LOAD;
            S_LOAD:   state_d = S_RUN;
            S_RUN: begin
                if (accept && opcode == OP_STOP)      state_d = S_HALT;
                else if (accept && opcode == OP_WAIT) state_d = S_WAIT;
            end
            S_HALT:   state_d = S_HALT;
            S_WAIT:   if (wake) state_d = S_RUN;
            default:  state_d = S_DUMMY0;
        endcase
    end

    // State register; reset restarts the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_DUMMY0;
        else        state_q <= state_d;
    end

    // Interrupt-take pulse on wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n) take_int_q <= 1'b0;
        else        take_int_q <= wake && (nmi || (irq && !irq_mask));
    end

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> (state_q == S_HALT));

    // R11
    take_int_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_int_q |-> ($past(nmi) || ($past(irq) && !$past(irq_mask))));
endmodule

// File: rtl/seq_bus.sv
// Module: seq_bus
// Drives the read bus during the dummy stack reads and the vector fetch,
// and captures the low vector byte.
// Assumes read data returns one cycle after the strobe.
module seq_bus
    import core_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-DW-1:0] STACK_PAGE = 'h01,
    parameter logic [AW-1:0]    VEC_ADDR   = 'hFFFC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_e      state_q,
    input  logic [DW-1:0]   sp_q,
    input  logic [DW-1:0]   bus_rdata,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_rd,
    output logic [DW-1:0]   vec_lo_q
);
    localparam logic [AW-1:0] VEC_ADDR_HI = VEC_ADDR + AW'(1);

    // Address and strobe per sequence state.
    always_comb begin
        bus_addr = '0;
        bus_rd   = 1'b0;
        unique case (state_q)
            S_DUMMY0, S_DUMMY1, S_DUMMY2: begin
                bus_addr = {STACK_PAGE, sp_q};
                bus_rd   = rst_n;
            end
            S_VLO: begin
                bus_addr = VEC_ADDR;
                bus_rd   = 1'b1;
            end
            S_VHI: begin
                bus_addr = VEC_ADDR_HI;
                bus_rd   = 1'b1;
            end
            default: ;
        endcase
    end

    // Capture the low vector byte returned during S_VHI.
    always_ff @(posedge clk) begin
        if (!rst_n)                vec_lo_q <= '0;
        else if (state_q == S_VHI) vec_lo_q <= bus_rdata;
    end

    // R1
    dummy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == {STACK_PAGE, {DW{1'b1}}})
            |-> ($past(bus_rd) && $past(bus_addr) == {STACK_PAGE, {DW{1'b0}}}));
endmodule

// File: rtl/seq_regs.sv
// Module: seq_regs
// Holds the program counter, the stack pointer and the executed pulse.
// Assumes op_len is the byte length reported by the external decoder.
module seq_regs
    import core_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       state_q,
    input  logic             accept,
    input  logic             single_byte,
    input  logic             op_valid,
    input  logic [LEN_W-1:0] op_len,
    input  logic [DW-1:0]    bus_rdata,
    input  logic [DW-1:0]    vec_lo_q,
    output logic [AW-1:0]    pc_q,
    output logic [DW-1:0]    sp_q,
    output logic             executed_q
);
    logic [AW-1:0] step;

    // Program-counter step size.
    always_comb step = single_byte ? AW'(1) : AW'(op_len);

    // Stack pointer: cleared by reset, decremented by each dummy read.
    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else if (state_q == S_DUMMY0 || state_q == S_DUMMY1 || state_q == S_DUMMY2)
            sp_q <= sp_q - DW'(1);
    end

    // Program counter: vector load, then advance per accepted opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pc_q <= '0;
        else if (state_q == S_LOAD) pc_q <= {bus_rdata, vec_lo_q};
        else if (accept)            pc_q <= pc_q + step;
    end

    // Completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) executed_q <= 1'b0;
        else        executed_q <= accept;
    end

    // R2
    sp_at_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_VLO) |-> (sp_q == DW'(8'hFD)));

    // R5
    exec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        executed_q |-> $past(op_valid));

    // R7
    halt_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> $stable(pc_q));
endmodule

// File: rtl/core_ctl_seq.sv
// Module: core_ctl_seq (top)
// Reset, stop and wait sequencer of an 8-bit core; gates instruction fetch.
// Assumes a synchronous read bus with one cycle of latency.
module core_ctl_seq
    import core_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_rd,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             op_valid,
    input  logic [DW-1:0]    opcode,
    input  logic [LEN_W-1:0] op_len,
    input  logic             irq,
    input  logic             nmi,
    input  logic             irq_mask,
    output logic             fetch_en,
    output logic             executed,
    output logic             halted,
    output logic             waiting,
    output logic             take_int,
    output logic [AW-1:0]    pc,
    output logic [DW-1:0]    sp
);
    seq_state_e    state_q;
    logic          accept;
    logic          single_byte;
    logic [DW-1:0] vec_lo_q;

    seq_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .irq(irq), .nmi(nmi), .irq_mask(irq_mask), .state_q(state_q),
        .accept(accept), .single_byte(single_byte), .take_int_q(take_int)
    );

    seq_bus #(.AW(AW), .DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .sp_q(sp),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .vec_lo_q(vec_lo_q)
    );

    seq_regs #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .accept(accept),
        .single_byte(single_byte), .op_valid(op_valid), .op_len(op_len),
        .bus_rdata(bus_rdata), .vec_lo_q(vec_lo_q), .pc_q(pc), .sp_q(sp),
        .executed_q(executed)
    );

    // Status decode of the sequencer state.
    always_comb begin
        fetch_en = (state_q == S_RUN);
        halted   = (state_q == S_HALT);
        waiting  = (state_q == S_WAIT);
    end

    // R4
    no_read_when_fetching_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |-> !bus_rd);
endmodule

// File: tb/tb_core_ctl_seq.sv
// Directed bench for core_ctl_seq: one task per scenario, each checking its results.
module tb_core_ctl_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic [7:0]  bus_rdata = 8'h00;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'hEA;
    logic [1:0]  op_len = 2'd1;
    logic        irq = 1'b0, nmi = 1'b0, irq_mask = 1'b0;
    logic        fetch_en, executed, halted, waiting, take_int;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [7:0]  vec_lo = 8'h34, vec_hi = 8'h12;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    core_ctl_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .op_valid(op_valid), .opcode(opcode),
        .op_len(op_len), .irq(irq), .nmi(nmi), .irq_mask(irq_mask),
        .fetch_en(fetch_en), .executed(executed), .halted(halted),
        .waiting(waiting), .take_int(take_int), .pc(pc), .sp(sp)
    );

    // Memory model: one cycle of read latency.
    always @(posedge clk) begin
        if (bus_rd) begin
            if (bus_addr == 16'hFFFC)      bus_rdata <= vec_lo;
            else if (bus_addr == 16'hFFFD) bus_rdata <= vec_hi;
            else                           bus_rdata <= bus_addr[7:0] ^ 8'h5A;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reset then check the dummy reads, the vector fetch and the start state.
    task automatic do_reset(input logic [15:0] vec, input bit strobe_ops);
        vec_lo = vec[7:0];
        vec_hi = vec[15:8];
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = strobe_ops;
        opcode = 8'hEA;
        op_len = 2'd1;
        @(negedge clk);
        @(negedge clk);
        check("R2 sp in reset", sp, 8'h00);
        check("R4 no read in reset", bus_rd, 1'b0);
        check("R8 halted cleared", halted, 1'b0);
        rst_n = 1'b1;
        #1;
        check("R1 rd0", {bus_rd, bus_addr}, {1'b1, 16'h0100});
        @(negedge clk);
        check("R1 rd1", {bus_rd, bus_addr}, {1'b1, 16'h01FF});
        check("R2 sp ff", sp, 8'hFF);
        @(negedge clk);
        check("R1 rd2", {bus_rd, bus_addr}, {1'b1, 16'h01FE});
        check("R2 sp fe", sp, 8'hFE);
        @(negedge clk);
        check("R3 vec lo", {bus_rd, bus_addr}, {1'b1, 16'hFFFC});
        check("R2 sp fd", sp, 8'hFD);
        @(negedge clk);
        check("R3 vec hi", {bus_rd, bus_addr}, {1'b1, 16'hFFFD});
        @(negedge clk);
        check("R4 load no read", {bus_rd, fetch_en}, 2'b00);
        if (strobe_ops) check("R12 no exec in seq", executed, 1'b0);
        op_valid = 1'b0;
        @(negedge clk);
        check("R3 fetch open", fetch_en, 1'b1);
        check("R3 pc vector", pc, vec);
        check("R2 sp at run", sp, 8'hFD);
        check("R12 no exec", executed, 1'b0);
    endtask

    // Present one opcode for one cycle and check the result.
    task automatic step(input string req, input logic [7:0] op, input logic [1:0] len,
                        input logic [15:0] exp_pc, input bit exp_exec);
        opcode = op;
        op_len = len;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check(req, executed, exp_exec);
        check(req, pc, exp_pc);
    endtask

    task automatic run_normal();
        logic [15:0] p = pc;
        step("R5 len2", 8'hA9, 2'd2, p + 16'd2, 1'b1);
        @(negedge clk);
        check("R5 single pulse", executed, 1'b0);
        step("R5 len3", 8'h4C, 2'd3, p + 16'd5, 1'b1);
        step("R5 back-to-back", 8'hEA, 2'd1, p + 16'd6, 1'b1);
        check("R4 no read while running", bus_rd, 1'b0);
    endtask

    task automatic run_stop();
        logic [15:0] p = pc;
        step("R6 stop", 8'hDB, 2'd3, p + 16'd1, 1'b1);
        check("R6 halted", {halted, fetch_en}, 2'b10);
        op_valid = 1'b1;
        opcode = 8'hEA;
        irq = 1'b1;
        nmi = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 no exec", executed, 1'b0);
            check("R7 pc held", pc, p + 16'd1);
            check("R7 still halted", {halted, bus_rd}, 2'b10);
        end
        op_valid = 1'b0;
        irq = 1'b0;
        nmi = 1'b0;
    endtask

    task automatic run_wait(input bit use_nmi, input bit mask, input bit exp_take);
        logic [15:0] p = pc;
        irq_mask = mask;
        step("R9 wait", 8'hCB, 2'd2, p + 16'd1, 1'b1);
        check("R9 waiting", {waiting, fetch_en}, 2'b10);
        op_valid = 1'b1;
        opcode = 8'hEA;
        @(negedge clk);
        op_valid = 1'b0;
        check("R9 ignored op", {executed, waiting}, 2'b01);
        check("R9 pc held", pc, p + 16'd1);
        if (use_nmi) nmi = 1'b1;
        else         irq = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        irq = 1'b0;
        check(use_nmi ? "R10 nmi wake" : "R11 irq wake", {waiting, fetch_en}, 2'b01);
        check(use_nmi ? "R10 take" : "R11 take", take_int, exp_take);
        check("R11 pc resume", pc, p + 16'd1);
        @(negedge clk);
        check("R10 take pulse ends", take_int, 1'b0);
        irq_mask = 1'b0;
    endtask

    initial begin
        do_reset(16'h1234, 1'b0);
        run_normal();
        run_stop();
        do_reset(16'h8000, 1'b0);
        run_normal();
        run_wait(1'b1, 1'b1, 1'b1);
        run_wait(1'b0, 1'b1, 1'b0);
        run_wait(1'b0, 1'b0, 1'b1);
        do_reset(16'hC0DE, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule